// File: doc/BRIEF.md
# Two-Level Address Translator with a Single Cached Translation

This block turns a 32-bit virtual address into a physical address. The mapping lives in memory as a two-level tree. The upper ten bits of the virtual address select an entry in a directory. That entry names the frame of a second-level table, the next ten bits select an entry in that table, and that entry names the physical frame. The low twelve bits pass through unchanged as the offset. A directory base register holds the frame number of the directory.

The block remembers one translation: the last virtual page number, its frame number, a valid bit and a global flag. A request whose page matches that entry is answered one cycle after it is accepted, with no memory traffic. Any other request starts a walk that makes two word reads, one for each level. The walk then answers and replaces the remembered entry. If either entry it fetches is marked not present, the walk answers with a fault and leaves the remembered entry alone.

Two control inputs maintain the entry. Loading a new directory base drops the entry unless its global flag is set. A single-page invalidate drops the entry whenever its page matches the given address, global or not.

Top module: `xlat_top`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, the directory base is 0, and no translation is remembered, so the first request makes memory reads.
- R2: The first read of a walk is at address `{base_frame, 12'h000} + 4 * vaddr[31:22]`, using the base value held when the request was accepted.
- R3: The second read of a walk is at `{dir_entry[31:12], 12'h000} + 4 * vaddr[21:12]`.
- R4: A walk that completes without fault returns `rsp_paddr = {tbl_entry[31:12], vaddr[11:0]}` with `rsp_fault` 0, `rsp_valid` high one cycle after the edge at which the second read data is taken. With a memory that grants each read at once and returns data one cycle later, this is 5 cycles after the request is accepted.
- R5: A request whose `vaddr[31:12]` equals the remembered page while the entry is valid gets `rsp_valid` with `{remembered_frame, vaddr[11:0]}` in the cycle after acceptance and makes no memory read.
- R6: A completed walk replaces the remembered entry, so the page that was remembered before it misses afterwards.
- R7: A write of the directory base (`base_wr_en` high) drops the remembered entry when its global flag is 0.
- R8: A write of the directory base keeps the remembered entry when its global flag is 1. The global flag is bit 8 of the second-level entry.
- R9: An invalidate (`inv_en` high) drops the remembered entry when `inv_vaddr[31:12]` equals its page, whatever its global flag, and has no effect on a different page.
- R10: Bit 0 of each fetched entry is the present bit. If it is 0, the walk ends at once with `rsp_valid` and `rsp_fault` both 1. A directory fault makes one read in total, a table fault makes two, and the remembered entry is unchanged.
- R11: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. `req_ready` is 0 for the whole walk. Each cycle a read is held off adds one cycle to the answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Block can accept a request (idle) |
| rsp_valid | output | 1 | One-cycle pulse carrying the answer |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault | output | 1 | Answer is a not-present fault |
| mem_req_valid | output | 1 | Table word read requested |
| mem_req_addr | output | 32 | Byte address of the table word |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Fetched table or directory entry |
| base_wr_en | input | 1 | Load a new directory base |
| base_wr_pfn | input | 20 | New directory frame number |
| inv_en | input | 1 | Invalidate one page |
| inv_vaddr | input | 32 | Address naming the page to invalidate |

## Verification
A hit is due one cycle after the accepting edge. With a memory that grants reads at once, a completed or table-faulting walk is due five cycles after acceptance and a directory fault three. Every held-off read cycle adds one. Each request task raises `req_valid` at a falling edge, counts rising edges from acceptance, and samples `rsp_valid` at each following falling edge. It then compares the measured latency and the number of reads the memory model granted with those figures. Base writes and invalidates take effect at the next rising edge, so the following request is issued one falling edge later and shows through hit or miss latency and read count whether the entry survived.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_DIR_REQ,
    WS_DIR_WAIT,
    WS_TBL_REQ,
    WS_TBL_WAIT
  } walk_st_e;

  // entry field positions decoded by the walker and the cache fill
  localparam int unsigned PRESENT_POS = 0;
  localparam int unsigned GLOBAL_POS  = 8;

endpackage

// File: rtl/xlat_tc1.sv
module xlat_tc1 #(
  parameter int unsigned PFN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PFN_W-1:0] look_vpn,
  output logic             hit,
  output logic [PFN_W-1:0] hit_pfn,
  input  logic             fill_en,
  input  logic [PFN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_glb,
  input  logic             flush_ng,
  input  logic             inv_en,
  input  logic [PFN_W-1:0] inv_vpn,
  output logic             ent_valid,
  output logic [PFN_W-1:0] ent_vpn,
  output logic             ent_glb
);

  logic             valid_q, valid_d;
  logic [PFN_W-1:0] vpn_q, pfn_q;
  logic             glb_q;

  // flush and invalidate act on the entry as held; a same-cycle fill wins
  always_comb begin
    valid_d = valid_q;
    if (flush_ng && !glb_q) valid_d = 1'b0;
    if (inv_en && (inv_vpn == vpn_q)) valid_d = 1'b0;
    if (fill_en) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      vpn_q <= fill_vpn;
      pfn_q <= fill_pfn;
      glb_q <= fill_glb;
    end
  end

  assign hit       = valid_q && (look_vpn == vpn_q);
  assign hit_pfn   = pfn_q;
  assign ent_valid = valid_q;
  assign ent_vpn   = vpn_q;
  assign ent_glb   = glb_q;

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned TIDX_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        start_va,
  input  logic [ADDR_W-OFF_W-1:0]  base_pfn,
  output logic                     mem_req_valid,
  output logic [ADDR_W-1:0]        mem_req_addr,
  input  logic                     mem_req_ready,
  input  logic                     mem_rsp_valid,
  input  logic [ADDR_W-1:0]        mem_rsp_data,
  output logic                     busy,
  output logic                     done_ok,
  output logic                     done_fault,
  output logic [ADDR_W-OFF_W-1:0]  done_pfn,
  output logic                     done_glb,
  output logic [ADDR_W-1:0]        walk_va
);

  localparam int unsigned PFN_W  = ADDR_W - OFF_W;
  localparam int unsigned DIDX_W = ADDR_W - OFF_W - TIDX_W;
  localparam int unsigned ENT_LG = 2;

  walk_st_e          st_q, st_d;
  logic [ADDR_W-1:0] va_q, addr_q, addr_d;
  logic              va_ld, addr_ld;
  logic              present;
  logic [DIDX_W-1:0] dir_idx;
  logic [TIDX_W-1:0] tbl_idx;
  logic [PFN_W-1:0]  ent_pfn;

  assign dir_idx = start_va[ADDR_W-1 -: DIDX_W];
  assign tbl_idx = va_q[OFF_W +: TIDX_W];
  assign ent_pfn = mem_rsp_data[ADDR_W-1:OFF_W];
  assign present = mem_rsp_data[PRESENT_POS];

  always_comb begin
    st_d       = st_q;
    va_ld      = 1'b0;
    addr_ld    = 1'b0;
    addr_d     = addr_q;
    done_ok    = 1'b0;
    done_fault = 1'b0;
    unique case (st_q)
      WS_IDLE: begin
        if (start) begin
          st_d    = WS_DIR_REQ;
          va_ld   = 1'b1;
          addr_ld = 1'b1;
          addr_d  = ADDR_W'({base_pfn, {OFF_W{1'b0}}})
                  + ADDR_W'({dir_idx, {ENT_LG{1'b0}}});
        end
      end
      WS_DIR_REQ:  if (mem_req_ready) st_d = WS_DIR_WAIT;
      WS_DIR_WAIT: begin
        if (mem_rsp_valid) begin
          if (!present) begin
            done_fault = 1'b1;
            st_d       = WS_IDLE;
          end else begin
            st_d    = WS_TBL_REQ;
            addr_ld = 1'b1;
            addr_d  = ADDR_W'({ent_pfn, {OFF_W{1'b0}}})
                    + ADDR_W'({tbl_idx, {ENT_LG{1'b0}}});
          end
        end
      end
      WS_TBL_REQ:  if (mem_req_ready) st_d = WS_TBL_WAIT;
      WS_TBL_WAIT: begin
        if (mem_rsp_valid) begin
          st_d       = WS_IDLE;
          done_ok    = present;
          done_fault = !present;
        end
      end
      default: st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (va_ld)   va_q   <= start_va;
    if (addr_ld) addr_q <= addr_d;
  end

  logic unused_ent_bits;
  assign unused_ent_bits = ^mem_rsp_data[OFF_W-1:0];

  assign mem_req_valid = (st_q == WS_DIR_REQ) || (st_q == WS_TBL_REQ);
  assign mem_req_addr  = addr_q;
  assign busy          = (st_q != WS_IDLE);
  assign done_pfn      = ent_pfn;
  assign done_glb      = mem_rsp_data[GLOBAL_POS];
  assign walk_va       = va_q;

endmodule

// File: rtl/xlat_top.sv
module xlat_top #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned TIDX_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_vaddr,
  output logic                    req_ready,
  output logic                    rsp_valid,
  output logic [ADDR_W-1:0]       rsp_paddr,
  output logic                    rsp_fault,
  output logic                    mem_req_valid,
  output logic [ADDR_W-1:0]       mem_req_addr,
  input  logic                    mem_req_ready,
  input  logic                    mem_rsp_valid,
  input  logic [ADDR_W-1:0]       mem_rsp_data,
  input  logic                    base_wr_en,
  input  logic [ADDR_W-OFF_W-1:0] base_wr_pfn,
  input  logic                    inv_en,
  input  logic [ADDR_W-1:0]       inv_vaddr
);

  localparam int unsigned PFN_W = ADDR_W - OFF_W;

  logic [PFN_W-1:0]  base_q;
  logic              busy, accept, hit, start;
  logic [PFN_W-1:0]  hit_pfn;
  logic              w_ok, w_fault, w_glb;
  logic [PFN_W-1:0]  w_pfn;
  logic [ADDR_W-1:0] w_va;
  logic              tlb_valid, tlb_global;
  logic [PFN_W-1:0]  tlb_vpn;

  logic              rsp_valid_d, rsp_fault_d;
  logic [ADDR_W-1:0] rsp_paddr_d;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign start     = accept && !hit;

  xlat_tc1 #(.PFN_W(PFN_W)) u_tc1 (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_vpn  (req_vaddr[ADDR_W-1:OFF_W]),
    .hit       (hit),
    .hit_pfn   (hit_pfn),
    .fill_en   (w_ok),
    .fill_vpn  (w_va[ADDR_W-1:OFF_W]),
    .fill_pfn  (w_pfn),
    .fill_glb  (w_glb),
    .flush_ng  (base_wr_en),
    .inv_en    (inv_en),
    .inv_vpn   (inv_vaddr[ADDR_W-1:OFF_W]),
    .ent_valid (tlb_valid),
    .ent_vpn   (tlb_vpn),
    .ent_glb   (tlb_global)
  );

  xlat_walker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .TIDX_W(TIDX_W)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_va      (req_vaddr),
    .base_pfn      (base_q),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .busy          (busy),
    .done_ok       (w_ok),
    .done_fault    (w_fault),
    .done_pfn      (w_pfn),
    .done_glb      (w_glb),
    .walk_va       (w_va)
  );

  logic unused_inv_off;
  assign unused_inv_off = ^inv_vaddr[OFF_W-1:0];

  always_comb begin
    rsp_valid_d = (accept && hit) || w_ok || w_fault;
    rsp_fault_d = w_fault;
    rsp_paddr_d = '0;
    if (accept && hit) rsp_paddr_d = {hit_pfn, req_vaddr[OFF_W-1:0]};
    else if (w_ok)     rsp_paddr_d = {w_pfn, w_va[OFF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      if (base_wr_en) base_q <= base_wr_pfn;
      rsp_valid <= rsp_valid_d;
      rsp_fault <= rsp_fault_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_valid_d) rsp_paddr <= rsp_paddr_d;
  end

endmodule

// File: rtl/xlat_chk.sv
module xlat_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [ADDR_W-1:0]       req_vaddr,
  input logic                    rsp_valid,
  input logic                    rsp_fault,
  input logic                    mem_req_valid,
  input logic                    mem_req_ready,
  input logic [ADDR_W-1:0]       mem_req_addr,
  input logic                    mem_rsp_valid,
  input logic                    base_wr_en,
  input logic                    inv_en,
  input logic [ADDR_W-1:0]       inv_vaddr,
  input logic                    tlb_valid,
  input logic [ADDR_W-OFF_W-1:0] tlb_vpn,
  input logic                    tlb_global
);

  p_hit_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && tlb_valid && (req_vaddr[ADDR_W-1:OFF_W] == tlb_vpn))
    |=> (rsp_valid && !rsp_fault && !mem_req_valid));

  p_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_busy_walk_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  p_flush_ng_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (base_wr_en && tlb_valid && !tlb_global && !mem_rsp_valid) |=> !tlb_valid);

  p_keep_glb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (base_wr_en && tlb_valid && tlb_global && !inv_en && !mem_rsp_valid) |=> tlb_valid);

  p_inv_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && tlb_valid && (inv_vaddr[ADDR_W-1:OFF_W] == tlb_vpn) && !mem_rsp_valid)
    |=> !tlb_valid);

  p_fault_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && !$past(base_wr_en) && !$past(inv_en))
    |-> ($stable(tlb_valid) && (!tlb_valid || $stable(tlb_vpn))));

endmodule

bind xlat_top xlat_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .rsp_valid     (rsp_valid),
  .rsp_fault     (rsp_fault),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .base_wr_en    (base_wr_en),
  .inv_en        (inv_en),
  .inv_vaddr     (inv_vaddr),
  .tlb_valid     (tlb_valid),
  .tlb_vpn       (tlb_vpn),
  .tlb_global    (tlb_global)
);

// File: tb/tb_xlat_top.sv
module tb_xlat_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        base_wr_en = 1'b0;
  logic [19:0] base_wr_pfn = '0;
  logic        inv_en = 1'b0;
  logic [31:0] inv_vaddr = '0;

  always #10 clk = ~clk;

  xlat_top dut (.*);

  int checks = 0;
  int failures = 0;
  bit ended = 0;

  // memory model: image, read grant with optional hold-off, data one cycle later
  logic [31:0] img [logic [31:0]];
  int          xfers = 0;
  int          served = 0;
  logic [31:0] xaddr [0:7];
  logic [31:0] last_addr;
  int          stall_cfg = 0;
  int          stall_ctr = 0;
  int          busy_bad = 0;

  function automatic logic [31:0] img_rd(logic [31:0] a);
    return img.exists(a) ? img[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      xaddr[xfers % 8] <= mem_req_addr;
      last_addr        <= mem_req_addr;
      xfers            <= xfers + 1;
    end
  end

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (served != xfers) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = img_rd(last_addr);
      served        = xfers;
    end
    if (!mem_req_valid) begin
      mem_req_ready = 1'b0;
      stall_ctr     = stall_cfg;
    end else if (stall_ctr > 0) begin
      stall_ctr = stall_ctr - 1;
    end else begin
      mem_req_ready = 1'b1;
    end
    if (mem_req_valid && req_ready) busy_bad++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dir_addr(logic [19:0] b, logic [31:0] va);
    return {b, 12'h000} + {20'h0, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] tbl_addr(logic [31:0] pde, logic [31:0] va);
    return {pde[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
  endfunction

  // one request; returns latency (edges from acceptance), reads granted, answer
  int          r_lat, r_reads, r_x0;
  logic [31:0] r_pa;
  logic        r_flt;

  task automatic do_req(input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    r_x0 = xfers;
    @(posedge clk);
    r_lat = 1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && r_lat < 200) begin
      @(posedge clk);
      r_lat++;
      @(negedge clk);
    end
    r_pa    = rsp_paddr;
    r_flt   = rsp_fault;
    r_reads = xfers - r_x0;
  endtask

  task automatic set_base(input logic [19:0] b);
    @(negedge clk);
    base_wr_en  = 1'b1;
    base_wr_pfn = b;
    @(negedge clk);
    base_wr_en  = 1'b0;
  endtask

  task automatic do_inv(input logic [31:0] va);
    @(negedge clk);
    inv_en    = 1'b1;
    inv_vaddr = va;
    @(negedge clk);
    inv_en    = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
  endtask

  task automatic t_miss();
    do_req(32'h0040_3ABC);
    chk(r_reads == 2, "R1 first request walks", 32'(r_reads), 32'd2);
    chk(xaddr[r_x0 % 8] == dir_addr(20'h00100, 32'h0040_3ABC), "R2 directory read address",
        xaddr[r_x0 % 8], dir_addr(20'h00100, 32'h0040_3ABC));
    chk(xaddr[(r_x0 + 1) % 8] == tbl_addr(32'h0020_0001, 32'h0040_3ABC), "R3 table read address",
        xaddr[(r_x0 + 1) % 8], tbl_addr(32'h0020_0001, 32'h0040_3ABC));
    chk(r_pa == 32'h1234_5ABC, "R4 walk paddr", r_pa, 32'h1234_5ABC);
    chk(r_flt == 1'b0, "R4 walk fault flag", 32'(r_flt), 32'd0);
    chk(r_lat == 5, "R4 walk latency", 32'(r_lat), 32'd5);
  endtask

  task automatic t_hit();
    do_req(32'h0040_3010);
    chk(r_reads == 0, "R5 hit reads", 32'(r_reads), 32'd0);
    chk(r_lat == 1, "R5 hit latency", 32'(r_lat), 32'd1);
    chk(r_pa == 32'h1234_5010, "R5 hit paddr", r_pa, 32'h1234_5010);
  endtask

  task automatic t_stall();
    stall_cfg = 3;
    do_req(32'h0040_4123);
    stall_cfg = 0;
    chk(r_pa == 32'h0ABC_D123, "R11 stalled walk paddr", r_pa, 32'h0ABC_D123);
    chk(r_lat == 11, "R11 stalled walk latency", 32'(r_lat), 32'd11);
    chk(busy_bad == 0, "R11 req_ready low during reads", 32'(busy_bad), 32'd0);
  endtask

  task automatic t_replace();
    do_req(32'h0040_3ABC);
    chk(r_reads == 2, "R6 old page misses", 32'(r_reads), 32'd2);
    do_req(32'h0040_4000);
    chk(r_reads == 2, "R6 replaced page misses", 32'(r_reads), 32'd2);
    chk(r_pa == 32'h0ABC_D000, "R6 refilled paddr", r_pa, 32'h0ABC_D000);
  endtask

  task automatic t_flush();
    do_req(32'h0040_3000);
    set_base(20'h00100);
    do_req(32'h0040_3004);
    chk(r_reads == 2, "R7 non-global dropped by base write", 32'(r_reads), 32'd2);
    chk(r_lat == 5, "R7 latency after flush", 32'(r_lat), 32'd5);
  endtask

  task automatic t_global();
    do_req(32'h0040_5777);
    chk(r_pa == 32'h5555_5777, "R8 global page paddr", r_pa, 32'h5555_5777);
    set_base(20'h00300);
    do_req(32'h0040_5001);
    chk(r_reads == 0, "R8 global kept across base write", 32'(r_reads), 32'd0);
    chk(r_pa == 32'h5555_5001, "R8 global hit paddr", r_pa, 32'h5555_5001);
    do_req(32'h0040_3ABC);
    chk(xaddr[r_x0 % 8] == dir_addr(20'h00300, 32'h0040_3ABC), "R2 new base used",
        xaddr[r_x0 % 8], dir_addr(20'h00300, 32'h0040_3ABC));
    do_req(32'h0040_5000);
  endtask

  task automatic t_inv();
    do_inv(32'h0040_3000);
    do_req(32'h0040_5008);
    chk(r_reads == 0, "R9 other-page invalidate ignored", 32'(r_reads), 32'd0);
    do_inv(32'h0040_5FFF);
    do_req(32'h0040_5008);
    chk(r_reads == 2, "R9 matching invalidate drops global", 32'(r_reads), 32'd2);
  endtask

  task automatic t_fault();
    do_req(32'h0080_0000);
    chk(r_flt == 1'b1, "R10 directory not present fault", 32'(r_flt), 32'd1);
    chk(r_reads == 1, "R10 directory fault reads", 32'(r_reads), 32'd1);
    chk(r_lat == 3, "R10 directory fault latency", 32'(r_lat), 32'd3);
    do_req(32'h0040_5010);
    chk(r_reads == 0, "R10 entry kept after directory fault", 32'(r_reads), 32'd0);
    do_req(32'h0040_6000);
    chk(r_flt == 1'b1, "R10 table not present fault", 32'(r_flt), 32'd1);
    chk(r_reads == 2, "R10 table fault reads", 32'(r_reads), 32'd2);
    do_req(32'h0040_5020);
    chk(r_reads == 0, "R10 entry kept after table fault", 32'(r_reads), 32'd0);
    chk(r_pa == 32'h5555_5020, "R10 kept entry paddr", r_pa, 32'h5555_5020);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    img[32'h0010_0004] = 32'h0020_0001;
    img[32'h0030_0004] = 32'h0020_0001;
    img[32'h0020_000C] = 32'h1234_5001;
    img[32'h0020_0010] = 32'h0ABC_D001;
    img[32'h0020_0014] = 32'h5555_5101;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    set_base(20'h00100);
    t_miss();
    t_hit();
    t_stall();
    t_replace();
    t_flush();
    t_global();
    t_inv();
    t_fault();
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    finish_run();
  end

endmodule